// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block times the output-offset correction cycle of a multi-channel analog signal path. A completed register write arms it. The next rising edge of the active-low serial select then starts a cycle. The block first waits a fixed settling interval with the signal path untouched. It then asserts a control that shorts the inputs together and runs a successive-approximation search on a 6-bit trim code, driven by a single comparator bit. At the end it stores the result and releases the path.

The cycle can be cut short in two ways. A new serial transaction that pulls the select low before the cycle ends aborts it. Dropping the chip enable (standby) also aborts it and returns the stored trim to mid-scale. All intervals are counted in system clocks and derived from the clock period by parameters. The default is a 4 ns clock, a 500 ns settle time and a 2.5 µs correction window. The analog comparator and the trim DAC sit outside the block.

Top module: `ocs_cal_seq`

## Requirements
- R1: A cycle starts on the clock edge that first sees `sel_n` high after low, and only when `chip_en` is high and a `wr_done` pulse has been seen since the last start (a `wr_done` in that same cycle counts). A rising `sel_n` with no such write starts nothing. `cal_busy` is high from the next cycle on.
- R2: After a start, the block stays busy with `in_short` low for exactly 125 clock cycles (500 ns at a 4 ns clock).
- R3: `in_short` is then high for exactly 6 × 104 = 624 cycles. On the following cycle `cal_busy` and `in_short` are both low.
- R4: The search runs MSB first. At the start of correction the trial code is 6'b100000. At the end of each bit period, `cmp_hi` = 1 clears the bit under test, and the next lower bit is then set. When the comparator reports 1 exactly when the trial code exceeds some value T, the stored result equals T.
- R5: While `in_short` is high, `trim_code` shows the trial code. At all other times it shows the last stored result.
- R6: A falling `sel_n` while busy aborts the cycle. On the next cycle the block is idle and `trim_code` equals the result stored before the cycle. A later rising `sel_n` with no new write does not restart.
- R7: While `chip_en` is low, the block is idle one cycle later, `trim_code` is 32 (mid-scale) and any cycle in progress is aborted. A `wr_done` seen while `chip_en` is low does not arm a cycle.
- R8: After reset, `cal_busy` and `in_short` are low and `trim_code` is 32.
- R9: `in_short` is never high unless `cal_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_en | input | 1 | High = active; low = standby |
| wr_done | input | 1 | One-cycle pulse when a register write completes |
| sel_n | input | 1 | Serial select, active low; its rising edge launches a cycle |
| cmp_hi | input | 1 | Comparator: 1 = residual offset above zero, so the trial code is too large |
| cal_busy | output | 1 | Settle or correction in progress |
| in_short | output | 1 | Inputs shorted; correction phase active |
| trim_code | output | 6 | Offset trim code driven to the DAC |

## Verification
Two functions can fall in one clock: arming by `wr_done` and launching by the rising `sel_n`. The bench drives both in the same cycle and expects the cycle to start on that edge, with the same settle and correction counts as a launch from an earlier write. A second pairing is standby and an active cycle: `chip_en` drops mid-correction, and the bench expects idle state and mid-scale trim one cycle later rather than the restored earlier result. The bench runs the search against a comparator modeled from a chosen target, with random and extreme targets. It checks the final trim against the target and checks phase lengths at the exact edge counts.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {
    OCS_IDLE    = 2'd0,
    OCS_SETTLE  = 2'd1,
    OCS_CORRECT = 2'd2
  } ocs_state_e;
endpackage

// File: rtl/ocs_launch.sv
module ocs_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic wr_done,
  input  logic sel_n,
  input  logic busy,
  output logic launch,
  output logic abort
);
  logic sel_q;
  logic armed_q, armed_d, armed_en;
  logic sel_rise, sel_fall;

  assign sel_rise = sel_n & ~sel_q;
  assign sel_fall = ~sel_n & sel_q;
  assign launch   = chip_en & sel_rise & ~busy & (armed_q | wr_done);
  assign abort    = busy & sel_fall;

  always_comb begin
    armed_d  = armed_q;
    armed_en = 1'b0;
    if (!chip_en) begin
      armed_d  = 1'b0;
      armed_en = 1'b1;
    end else if (launch) begin
      armed_d  = 1'b0;
      armed_en = 1'b1;
    end else if (wr_done) begin
      armed_d  = 1'b1;
      armed_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      sel_q <= sel_n;
      if (armed_en) armed_q <= armed_d;
    end
  end

  // R7: writes seen in standby leave nothing armed
  p_arm_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !armed_q);
endmodule

// File: rtl/ocs_timer.sv
module ocs_timer #(
  parameter int MAX_LOAD = 124,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (!done) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: interval counter never exceeds the largest load value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LOAD));
endmodule

// File: rtl/ocs_sar.sv
module ocs_sar #(
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              start,
  input  logic              step,
  input  logic              cmp_hi,
  output logic [TRIM_W-1:0] trial,
  output logic [TRIM_W-1:0] result,
  output logic              last
);
  localparam logic [TRIM_W-1:0] TOP_BIT = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [TRIM_W-1:0] trial_q, trial_d, mask_q, mask_d, result_q, result_d;
  logic [TRIM_W-1:0] decided;
  logic              srch_en, res_en;

  assign trial  = trial_q;
  assign result = result_q;
  assign last   = mask_q[0];
  assign decided = cmp_hi ? (trial_q & ~mask_q) : trial_q;

  always_comb begin
    trial_d  = trial_q;
    mask_d   = mask_q;
    result_d = result_q;
    srch_en  = 1'b0;
    res_en   = 1'b0;
    if (!chip_en) begin
      result_d = TOP_BIT;
      res_en   = 1'b1;
    end else if (start) begin
      trial_d = TOP_BIT;
      mask_d  = TOP_BIT;
      srch_en = 1'b1;
    end else if (step) begin
      trial_d = decided | (mask_q >> 1);
      mask_d  = mask_q >> 1;
      srch_en = 1'b1;
      if (mask_q[0]) begin
        result_d = decided;
        res_en   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= TOP_BIT;
      mask_q   <= '0;
      result_q <= TOP_BIT;
    end else begin
      if (srch_en) begin
        trial_q <= trial_d;
        mask_q  <= mask_d;
      end
      if (res_en) result_q <= result_d;
    end
  end

  // R4: at most one bit is under test at a time
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
endmodule

// File: rtl/ocs_cal_seq.sv
module ocs_cal_seq #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETTLE_NS     = 500,
  parameter int CORRECT_NS    = 2500,
  parameter int TRIM_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              wr_done,
  input  logic              sel_n,
  input  logic              cmp_hi,
  output logic              cal_busy,
  output logic              in_short,
  output logic [TRIM_W-1:0] trim_code
);
  import ocs_pkg::*;

  localparam int SETTLE_CYC = (SETTLE_NS * 1000) / CLK_PERIOD_PS;
  localparam int BIT_CYC    = (CORRECT_NS * 1000) / (CLK_PERIOD_PS * TRIM_W);
  localparam int MAX_LOAD   = ((SETTLE_CYC > BIT_CYC) ? SETTLE_CYC : BIT_CYC) - 1;
  localparam int CNT_W      = $clog2(MAX_LOAD + 1);
  localparam logic [CNT_W-1:0]  SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0]  BIT_LOAD    = CNT_W'(BIT_CYC - 1);
  localparam logic [TRIM_W-1:0] MID_CODE    = {1'b1, {(TRIM_W-1){1'b0}}};

  ocs_state_e state_q, state_d;
  logic launch, abort, busy;
  logic tload, tdone;
  logic [CNT_W-1:0] tval;
  logic sar_start, sar_step, sar_last;
  logic [TRIM_W-1:0] sar_trial, sar_result;

  assign busy      = (state_q != OCS_IDLE);
  assign cal_busy  = busy;
  assign in_short  = (state_q == OCS_CORRECT);
  assign trim_code = in_short ? sar_trial : sar_result;

  ocs_launch u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .wr_done (wr_done),
    .sel_n   (sel_n),
    .busy    (busy),
    .launch  (launch),
    .abort   (abort)
  );

  ocs_timer #(.MAX_LOAD(MAX_LOAD), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tload),
    .load_val (tval),
    .done     (tdone)
  );

  ocs_sar #(.TRIM_W(TRIM_W)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .chip_en (chip_en),
    .start   (sar_start),
    .step    (sar_step),
    .cmp_hi  (cmp_hi),
    .trial   (sar_trial),
    .result  (sar_result),
    .last    (sar_last)
  );

  always_comb begin
    state_d   = state_q;
    tload     = 1'b0;
    tval      = '0;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    if (!chip_en) begin
      state_d = OCS_IDLE;
    end else begin
      unique case (state_q)
        OCS_IDLE: if (launch) begin
          state_d = OCS_SETTLE;
          tload   = 1'b1;
          tval    = SETTLE_LOAD;
        end
        OCS_SETTLE: if (abort) begin
          state_d = OCS_IDLE;
        end else if (tdone) begin
          state_d   = OCS_CORRECT;
          tload     = 1'b1;
          tval      = BIT_LOAD;
          sar_start = 1'b1;
        end
        OCS_CORRECT: if (abort) begin
          state_d = OCS_IDLE;
        end else if (tdone) begin
          sar_step = 1'b1;
          if (sar_last) begin
            state_d = OCS_IDLE;
          end else begin
            tload = 1'b1;
            tval  = BIT_LOAD;
          end
        end
        default: state_d = OCS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OCS_IDLE;
    else        state_q <= state_d;
  end

  // R1: an accepted launch enters the settle phase
  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (state_q == OCS_SETTLE));

  // R6: an abort returns to idle with the earlier result on the output
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && chip_en) |=> (state_q == OCS_IDLE && trim_code == $past(sar_result)));

  // R7: standby forces idle and mid-scale trim
  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!cal_busy && trim_code == MID_CODE));

  // R9: the input short is only applied inside a cycle
  p_short_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_short |-> cal_busy);
endmodule

// File: tb/ocs_cal_seq_tb.sv
module ocs_cal_seq_tb_top;
  localparam int SETTLE = 125;
  localparam int BITC   = 104;
  localparam int CORR   = 6 * BITC;
  localparam int TOTAL  = SETTLE + CORR;

  logic clk = 1'b0;
  logic rst_n, chip_en, wr_done, sel_n, cmp_hi;
  logic cal_busy, in_short;
  logic [5:0] trim_code;
  logic [5:0] tgt;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign cmp_hi = (trim_code > tgt);

  ocs_cal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_done(wr_done),
    .sel_n(sel_n), .cmp_hi(cmp_hi), .cal_busy(cal_busy),
    .in_short(in_short), .trim_code(trim_code)
  );

  function automatic logic [5:0] sar_expect(input logic [5:0] t);
    logic [5:0] code = 6'd0;
    for (int b = 5; b >= 0; b--) begin
      code[b] = 1'b1;
      if (code > t) code[b] = 1'b0;
    end
    return code;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ends on the negedge where sel_n is raised
  task automatic do_write(input bit coincide);
    @(negedge clk) sel_n = 1'b0;
    repeat (3) @(negedge clk);
    if (!coincide) begin
      wr_done = 1'b1;
      @(negedge clk) wr_done = 1'b0;
      @(negedge clk) sel_n = 1'b1;
    end else begin
      @(negedge clk);
      wr_done = 1'b1;
      sel_n   = 1'b1;
    end
  endtask

  task automatic run_cal(input logic [5:0] t, input bit coincide);
    bit short_ok = 1;
    tgt = t;
    do_write(coincide);
    for (int k = 1; k <= TOTAL + 1; k++) begin
      @(negedge clk);
      wr_done = 1'b0;
      if (in_short && !cal_busy) short_ok = 0;
      if (k == 1) chk(cal_busy && !in_short, "R1 launch", cal_busy, 1);
      if (k == SETTLE) chk(cal_busy && !in_short, "R2 settle end", in_short, 0);
      if (k == SETTLE + 1) begin
        chk(in_short, "R3 short start", in_short, 1);
        chk(trim_code == 6'd32, "R4/R5 first trial", trim_code, 32);
      end
      if (k == TOTAL) chk(in_short, "R3 short last", in_short, 1);
      if (k == TOTAL + 1) begin
        chk(!cal_busy && !in_short, "R3 release", cal_busy, 0);
        chk(trim_code == sar_expect(t), "R4 result", trim_code, sar_expect(t));
      end
    end
    chk(short_ok, "R9 short within busy", short_ok, 1);
  endtask

  task automatic idle_watch(input int n, input string req);
    bit quiet = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cal_busy) quiet = 0;
    end
    chk(quiet, req, !quiet, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c5));
    rst_n = 1'b0; chip_en = 1'b1; wr_done = 1'b0; sel_n = 1'b1; tgt = 6'd0;
    repeat (3) @(negedge clk);
    chk(!cal_busy && !in_short, "R8 reset idle", cal_busy, 0);
    chk(trim_code == 6'd32, "R8 reset trim", trim_code, 32);
    rst_n = 1'b1;

    // R1: select toggle with no write
    @(negedge clk) sel_n = 1'b0;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    idle_watch(20, "R1 no write no launch");

    run_cal(6'd45, 1'b0);
    run_cal(6'd0, 1'b1);     // R1: arm and launch in same cycle
    run_cal(6'd63, 1'b0);
    run_cal(6'd45, 1'b0);

    // R6: abort during settle
    tgt = 6'd10;
    do_write(1'b0);
    repeat (50) @(negedge clk);
    chk(cal_busy && !in_short, "R2 still settling", cal_busy, 1);
    sel_n = 1'b0;
    @(negedge clk);
    chk(!cal_busy, "R6 abort settle idle", cal_busy, 0);
    chk(trim_code == 6'd45, "R6 abort settle trim", trim_code, 45);
    sel_n = 1'b1;
    idle_watch(200, "R6 no relaunch");

    // R6: abort during correction
    do_write(1'b0);
    repeat (SETTLE + 200) @(negedge clk);
    chk(in_short && trim_code != 6'd45, "R5 trial shown", trim_code, -1);
    sel_n = 1'b0;
    @(negedge clk);
    chk(!cal_busy && !in_short, "R6 abort correct idle", cal_busy, 0);
    chk(trim_code == 6'd45, "R6 abort correct trim", trim_code, 45);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: standby during correction
    tgt = 6'd5;
    do_write(1'b0);
    repeat (SETTLE + 300) @(negedge clk);
    chip_en = 1'b0;
    @(negedge clk);
    chk(!cal_busy && !in_short, "R7 standby aborts", cal_busy, 0);
    chk(trim_code == 6'd32, "R7 standby mid trim", trim_code, 32);
    // R7: write seen in standby does not arm
    do_write(1'b0);
    @(negedge clk) chip_en = 1'b1;
    sel_n = 1'b0;
    @(negedge clk) sel_n = 1'b1;
    idle_watch(150, "R7 standby write ignored");
    chk(trim_code == 6'd32, "R7 trim kept mid", trim_code, 32);

    for (int i = 0; i < 6; i++) run_cal(6'($urandom % 64), i[0]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule